// File: doc/BRIEF.md
# Strided Load Address Predictor

This block predicts the effective address of a memory instruction from its instruction address alone, so a consumer can start a data transfer before the real address has been computed. A direct-mapped table is indexed by low instruction-address bits and tagged with the upper bits. For each entry the table learns the distance between successive actual addresses. It issues a prediction only after that distance has repeated often enough to be trusted, and only while it holds a valid running predicted address. The same table serves loads and stores alike.

Four ports drive the table. A lookup port asks for a prediction and gets a registered answer one cycle later. An update port carries the actual address once it is computed, and trains the entry. A mispredict-report port counts wrong guesses, and an entry that keeps guessing wrong is wiped. A global flush, raised on every branch mispredict, invalidates the running predicted address of every entry, so each entry must see a fresh actual address before it predicts again.

Top module: `stride_addr_pred`

## Requirements
- R1: While `rst` is high every entry becomes empty and `pred_valid` reads 0 in the cycle after reset.
- R2: The answer to a lookup raised in cycle t appears on `pred_valid`/`pred_addr` in cycle t+1. `pred_valid` is 0 after a cycle with no lookup, and after a lookup whose entry is empty or holds a different tag.
- R3: An entry is allocated by an update and is trained once five successive updates each differ from the update before by one and the same amount (six addresses since allocation). An update whose difference departs from the candidate stride makes that difference the new candidate and restarts the count at one.
- R4: A lookup yields no prediction while its entry is untrained or its running predicted address is invalid.
- R5: The update that completes training loads the running predicted address with that update's address. Each hitting lookup returns running address plus stride, modulo 2^ADDR_W, so negative strides wrap, and it advances the running address to that value. Updates to a trained entry with a valid running address leave it unchanged.
- R6: `flush` invalidates the running predicted address in every entry, and a lookup in the flush cycle gets no prediction. The next update to a trained entry re-establishes the running address with the update's address.
- R7: Mispredict reports whose instruction address matches an entry's tag are counted. The sixth such report since allocation clears the entry completely, so training starts over. A report carrying another tag has no effect.
- R8: The index is `pc[OFF_W+IDX_W-1:OFF_W]` and the tag is the bits above it. An update whose tag differs from the stored one reallocates the entry and discards its training.
- R9: When several ports address one entry in the same cycle, their effects apply in the order update, mispredict report, flush, lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Instruction address to predict for |
| pred_valid | output | 1 | Registered: a prediction was made |
| pred_addr | output | ADDR_W | Registered predicted address |
| upd_valid | input | 1 | Actual address available |
| upd_pc | input | PC_W | Instruction address of the update |
| upd_addr | input | ADDR_W | Actual computed address |
| mp_valid | input | 1 | Address mispredict report |
| mp_pc | input | PC_W | Instruction address that mispredicted |
| flush | input | 1 | Branch mispredict: invalidate all running addresses |

## Verification
The bench aims at the boundary of training: the fifth matching difference must enable prediction, and the fourth must not. A stride change partway through must restart the count, so a design with an off-by-one or a count that is not reset would predict early. Flush is exercised alone, together with a lookup, and together with an update in the same cycle. A design that lets the update win over the flush, or that keeps the running address after a flush, would predict where none is due. The sixth mispredict report, a foreign-tag report, a tag conflict and a negative stride are also covered; counting five instead of six, or ignoring the tag, shows up as a prediction present or missing on the cycle after the lookup.

// File: rtl/stride_pred_entry.sv
module stride_pred_entry #(
  parameter int TAG_W      = 26,
  parameter int ADDR_W     = 32,
  parameter int CONF_LIMIT = 5,
  parameter int MISS_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_sel,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              mp_sel,
  input  logic [TAG_W-1:0]  mp_tag,
  input  logic              flush,
  input  logic              lk_sel,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_addr
);
  localparam int CW = $clog2(CONF_LIMIT + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic              vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [CW-1:0]     conf_q, conf_d;
  logic              trained_q, trained_d;
  logic [ADDR_W-1:0] run_q, run_d;
  logic              run_ok_q, run_ok_d;
  logic [MW-1:0]     miss_q, miss_d;
  logic [ADDR_W-1:0] diff;

  assign diff = upd_addr - last_q;

  always_comb begin
    vld_d     = vld_q;
    tag_d     = tag_q;
    last_d    = last_q;
    stride_d  = stride_q;
    conf_d    = conf_q;
    trained_d = trained_q;
    run_d     = run_q;
    run_ok_d  = run_ok_q;
    miss_d    = miss_q;
    lk_hit    = 1'b0;
    lk_addr   = '0;
    // stage 1: update
    if (upd_sel) begin
      if (!vld_q || tag_q != upd_tag) begin
        vld_d     = 1'b1;
        tag_d     = upd_tag;
        last_d    = upd_addr;
        stride_d  = '0;
        conf_d    = '0;
        trained_d = 1'b0;
        run_d     = '0;
        run_ok_d  = 1'b0;
        miss_d    = '0;
      end else begin
        last_d = upd_addr;
        if (!trained_q) begin
          if (conf_q != '0 && diff == stride_q) conf_d = conf_q + 1'b1;
          else begin
            stride_d = diff;
            conf_d   = CW'(1);
          end
          if (conf_d == CW'(CONF_LIMIT)) begin
            trained_d = 1'b1;
            run_d     = upd_addr;
            run_ok_d  = 1'b1;
          end
        end else if (!run_ok_q) begin
          run_d    = upd_addr;
          run_ok_d = 1'b1;
        end
      end
    end
    // stage 2: mispredict report
    if (mp_sel && vld_d && tag_d == mp_tag) begin
      if (miss_d == MW'(MISS_LIMIT)) begin
        vld_d     = 1'b0;
        tag_d     = '0;
        last_d    = '0;
        stride_d  = '0;
        conf_d    = '0;
        trained_d = 1'b0;
        run_d     = '0;
        run_ok_d  = 1'b0;
        miss_d    = '0;
      end else begin
        miss_d = miss_d + 1'b1;
      end
    end
    // stage 3: global flush
    if (flush) run_ok_d = 1'b0;
    // stage 4: lookup
    if (lk_sel && vld_d && tag_d == lk_tag && trained_d && run_ok_d) begin
      lk_hit  = 1'b1;
      lk_addr = run_d + stride_d;
      run_d   = lk_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      tag_q     <= '0;
      last_q    <= '0;
      stride_q  <= '0;
      conf_q    <= '0;
      trained_q <= 1'b0;
      run_q     <= '0;
      run_ok_q  <= 1'b0;
      miss_q    <= '0;
    end else begin
      vld_q     <= vld_d;
      tag_q     <= tag_d;
      last_q    <= last_d;
      stride_q  <= stride_d;
      conf_q    <= conf_d;
      trained_q <= trained_d;
      run_q     <= run_d;
      run_ok_q  <= run_ok_d;
      miss_q    <= miss_d;
    end
  end
endmodule

// File: rtl/stride_addr_pred.sv
module stride_addr_pred #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int OFF_W      = 2,
  parameter int CONF_LIMIT = 5,
  parameter int MISS_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_addr,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              mp_valid,
  input  logic [PC_W-1:0]   mp_pc,
  input  logic              flush
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - OFF_W;
  localparam int TAG_LSB = IDX_W + OFF_W;

  logic [IDX_W-1:0]  lk_idx, upd_idx, mp_idx;
  logic [TAG_W-1:0]  lk_tag, upd_tag, mp_tag;
  logic              hit_vec [ENTRIES];
  logic [ADDR_W-1:0] addr_vec [ENTRIES];

  assign lk_idx  = lk_pc[TAG_LSB-1:OFF_W];
  assign upd_idx = upd_pc[TAG_LSB-1:OFF_W];
  assign mp_idx  = mp_pc[TAG_LSB-1:OFF_W];
  assign lk_tag  = lk_pc[PC_W-1:TAG_LSB];
  assign upd_tag = upd_pc[PC_W-1:TAG_LSB];
  assign mp_tag  = mp_pc[PC_W-1:TAG_LSB];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    stride_pred_entry #(
      .TAG_W(TAG_W), .ADDR_W(ADDR_W),
      .CONF_LIMIT(CONF_LIMIT), .MISS_LIMIT(MISS_LIMIT)
    ) u_entry (
      .clk(clk), .rst(rst),
      .upd_sel(upd_valid && upd_idx == IDX_W'(i)),
      .upd_tag(upd_tag), .upd_addr(upd_addr),
      .mp_sel(mp_valid && mp_idx == IDX_W'(i)),
      .mp_tag(mp_tag), .flush(flush),
      .lk_sel(lk_valid && lk_idx == IDX_W'(i)),
      .lk_tag(lk_tag),
      .lk_hit(hit_vec[i]), .lk_addr(addr_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_addr  <= '0;
    end else begin
      pred_valid <= hit_vec[lk_idx];
      pred_addr  <= hit_vec[lk_idx] ? addr_vec[lk_idx] : '0;
    end
  end
endmodule

// File: rtl/stride_addr_pred_chk.sv
module stride_addr_pred_chk (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic upd_valid,
  input logic flush,
  input logic pred_valid
);
  // R1
  reset_out_low_chk: assert property (@(posedge clk) $fell(rst) |-> !pred_valid);
  // R2
  no_lookup_no_pred_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);
  // R6
  flush_blocks_pred_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_valid);
  // R6
  flush_needs_reestablish_chk: assert property (@(posedge clk) disable iff (rst)
    flush ##1 (lk_valid && !upd_valid) |=> !pred_valid);
endmodule

bind stride_addr_pred stride_addr_pred_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .upd_valid(upd_valid),
  .flush(flush), .pred_valid(pred_valid)
);

// File: tb/stride_addr_pred_test.sv
module stride_addr_pred_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, upd_valid = 1'b0, mp_valid = 1'b0, flush = 1'b0;
  logic [31:0] lk_pc = '0, upd_pc = '0, upd_addr = '0, mp_pc = '0;
  logic        pred_valid;
  logic [31:0] pred_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state per index
  bit          m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_last [16], m_str [16], m_run [16];
  int          m_conf [16], m_miss [16];
  bit          m_tr [16], m_ok [16];

  always #4ns clk = ~clk;

  stride_addr_pred uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_addr(pred_addr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_addr(upd_addr),
    .mp_valid(mp_valid), .mp_pc(mp_pc), .flush(flush)
  );

  task automatic wipe(int i);
    m_vld[i] = 0; m_tag[i] = '0; m_last[i] = '0; m_str[i] = '0; m_run[i] = '0;
    m_conf[i] = 0; m_miss[i] = 0; m_tr[i] = 0; m_ok[i] = 0;
  endtask

  task automatic model(input bit lk, input logic [31:0] lpc, input bit up,
                       input logic [31:0] upc, input logic [31:0] ua,
                       input bit mp, input logic [31:0] mpc, input bit fl,
                       output bit ev, output logic [31:0] ea);
    int i;
    logic [31:0] d;
    ev = 0; ea = '0;
    if (up) begin
      i = int'(upc[5:2]);
      if (!m_vld[i] || m_tag[i] != upc[31:6]) begin
        wipe(i); m_vld[i] = 1; m_tag[i] = upc[31:6]; m_last[i] = ua;
      end else begin
        d = ua - m_last[i]; m_last[i] = ua;
        if (!m_tr[i]) begin
          if (m_conf[i] != 0 && d == m_str[i]) m_conf[i]++;
          else begin m_str[i] = d; m_conf[i] = 1; end
          if (m_conf[i] == 5) begin m_tr[i] = 1; m_run[i] = ua; m_ok[i] = 1; end
        end else if (!m_ok[i]) begin
          m_run[i] = ua; m_ok[i] = 1;
        end
      end
    end
    if (mp) begin
      i = int'(mpc[5:2]);
      if (m_vld[i] && m_tag[i] == mpc[31:6]) begin
        if (m_miss[i] == 5) wipe(i);
        else m_miss[i]++;
      end
    end
    if (fl) for (int k = 0; k < 16; k++) m_ok[k] = 0;
    if (lk) begin
      i = int'(lpc[5:2]);
      if (m_vld[i] && m_tag[i] == lpc[31:6] && m_tr[i] && m_ok[i]) begin
        ev = 1; ea = m_run[i] + m_str[i]; m_run[i] = ea;
      end
    end
  endtask

  task automatic check(string req, bit ev, logic [31:0] ea);
    checks++;
    if (pred_valid !== ev || (ev && pred_addr !== ea)) begin
      fails++;
      $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, pred_valid, pred_addr, ev, ea);
    end
  endtask

  // one clock: drive at negedge, compare at next negedge
  task automatic cyc(bit lk, logic [31:0] lpc, bit up, logic [31:0] upc,
                     logic [31:0] ua, bit mp, logic [31:0] mpc, bit fl, string req);
    bit ev;
    logic [31:0] ea;
    lk_valid = lk; lk_pc = lpc; upd_valid = up; upd_pc = upc; upd_addr = ua;
    mp_valid = mp; mp_pc = mpc; flush = fl;
    model(lk, lpc, up, upc, ua, mp, mpc, fl, ev, ea);
    @(posedge clk);
    @(negedge clk);
    check(req, ev, ea);
  endtask

  task automatic look(logic [31:0] pc, string req);
    cyc(1, pc, 0, '0, '0, 0, '0, 0, req);
  endtask

  task automatic upd(logic [31:0] pc, logic [31:0] a, string req);
    cyc(0, '0, 1, pc, a, 0, '0, 0, req);
  endtask

  localparam logic [31:0] PA = 32'h1000, PB = 32'h1004, PD = 32'h1008;
  localparam logic [31:0] PC_CONF = 32'h2000, PD_FOREIGN = 32'h2008;

  initial begin
    for (int k = 0; k < 16; k++) wipe(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: output low right after reset
    checks++;
    if (pred_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got valid=%0b, expected valid=0", pred_valid);
    end
    look(PA, "R2 empty entry");
    // R3/R4: train stride 8, no prediction until sixth address
    for (int k = 0; k < 6; k++) begin
      upd(PA, 32'h100 + 32'(8 * k), "R3");
      look(PA, k < 5 ? "R4 untrained" : "R5 first prediction");
    end
    look(PA, "R5 advance");
    upd(PA, 32'h130, "R5");
    look(PA, "R5 update keeps running addr");
    cyc(1, PA, 0, '0, '0, 0, '0, 1, "R6 flush-cycle lookup");
    look(PA, "R6 after flush");
    upd(PA, 32'h200, "R6");
    look(PA, "R6 re-established");
    // R9: flush wins over same-cycle update
    cyc(0, '0, 1, PA, 32'h300, 0, '0, 1, "R9");
    look(PA, "R9 flush after update");
    // R3: stride change restarts the count
    upd(PB, 32'h0, "R3");
    upd(PB, 32'h4, "R3");
    upd(PB, 32'h8, "R3");
    upd(PB, 32'hC, "R3");
    for (int k = 1; k <= 5; k++) begin
      upd(PB, 32'hC + 32'(8 * k), "R3");
      look(PB, k < 5 ? "R3 restarted count" : "R3 new stride trained");
    end
    // R9 and R5: update completing training seen by same-cycle lookup, negative stride
    for (int k = 0; k < 5; k++) upd(PD, 32'h5000 - 32'(16 * k), "R3");
    cyc(1, PD, 1, PD, 32'h4FB0, 0, '0, 0, "R9 update before lookup");
    look(PD, "R5 negative stride");
    // R7: five reports tolerated, foreign tag ignored, sixth clears
    for (int k = 0; k < 5; k++) cyc(1, PD, 0, '0, '0, 1, PD, 0, "R7 tolerated");
    cyc(1, PD, 0, '0, '0, 1, PD_FOREIGN, 0, "R7 foreign tag");
    cyc(1, PD, 0, '0, '0, 1, PD, 0, "R7 sixth clears");
    upd(PD, 32'h4000, "R7");
    look(PD, "R7 retraining needed");
    // R8: tag conflict reallocates
    look(PA, "R8 before conflict");
    upd(PC_CONF, 32'h9000, "R8");
    look(PA, "R8 old tag gone");
    look(PC_CONF, "R8 new tag untrained");
    cyc(0, '0, 0, '0, '0, 0, '0, 0, "R2 idle");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule